// File: doc/BRIEF.md
# Port Pin Controller with Peripheral Takeover

This block drives the pad controls of one small microcontroller port. Each pin has a seven-field configuration byte. A shared port data byte supplies the value each pin drives. From these two sources the block produces, for every pin, an output value, a tristate enable and a pull-up enable. It also passes the pin's high-sink select and input-threshold select straight through to the pad. The interrupt enable and interrupt polarity bits are stored and exported for an edge detector that sits elsewhere.

Two alternate functions can take a pin away from general-purpose use. A crystal-oscillator enable input takes over the two clock pins, which then go completely quiet. A 4-pin SPI peripheral takes over its select, clock, MOSI and MISO pins for each pin whose SPI-use bit is set. The pad input of every pin can always be read back through a two-flop synchronizer, whatever the pin is driving.

A simple register bus gives access to the state. Writes are single-cycle and reads are registered. Addresses 0 to NUM_PINS-1 hold the pin configuration bytes. Address NUM_PINS is the port data byte: a write sets the drive values and a read returns the synchronized pad inputs. Address NUM_PINS+1 holds the SPI-use bits.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, every pad control, every exported bit and `reg_rdata` are 0. All configuration, data and SPI-use state resets to 0.
- R2: A configuration byte reads back at its address (pin index) one cycle after the address is presented. Bits 6:0 hold what was written. Bit 7 always reads 0, and a write to bit 7 is ignored.
- R3: A pin in GPIO mode with configuration bit 0 (output enable) set and bit 2 (open drain) clear has `pad_oe`=1 and `pad_out` equal to its port data bit.
- R4: A pin in GPIO mode with bit 0 and bit 2 both set has `pad_oe`=0 when its data bit is 1. When its data bit is 0 it has `pad_oe`=1 and `pad_out`=0.
- R5: A pin in GPIO mode with bit 0 clear has `pad_oe`=0, whatever its open-drain and data bits are.
- R6: `pad_pu` follows configuration bit 1, `pad_hsink` bit 3, `pad_ttl` bit 4, `irq_low` bit 5 and `irq_en` bit 6. This holds in GPIO mode (including open drain with data 1) and under SPI takeover.
- R7: While `xtal_en` is 1, pins XTAL_IN_PIN (0) and XTAL_OUT_PIN (1) have every pad control and exported bit at 0, whatever their configuration bytes hold.
- R8: When SPI-use bit k (register NUM_PINS+1; bits 0..3 map to select, clock, MOSI, MISO) is 1, pin SPI_BASE+k (3 to 6) takes `pad_oe`=`spi_oe[k]` and `pad_out`=`spi_oe[k]`&`spi_out[k]`. When the bit is 0, the pin follows R3 to R5.
- R9: A read at address NUM_PINS returns the `pad_in` value sampled three clock edges earlier (two synchronizer stages plus the read register). The value does not depend on the drive state.
- R10: All pad controls are registered. A register write at edge E shows on the pads after edge E+1, a change of `xtal_en` or the SPI inputs at edge E shows after E, and `pad_out` is never 1 while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| xtal_en | input | 1 | Crystal oscillator enable, takes over the two clock pins |
| spi_oe | input | 4 | SPI drive enables (select, clock, MOSI, MISO) |
| spi_out | input | 4 | SPI drive values |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pad pull-up enables |
| pad_hsink | output | NUM_PINS | High-sink select per pin |
| pad_ttl | output | NUM_PINS | Input threshold select per pin |
| irq_en | output | NUM_PINS | Exported interrupt enable per pin |
| irq_low | output | NUM_PINS | Exported interrupt active-low per pin |

## Verification
Each configuration mode is tried with alternating data bytes (0xAA, 0x55, 0xF0). This separates push-pull, where the output follows the data, from open drain, where the enable follows the inverted data, and from the disabled case, where data has no effect. The crystal pins are loaded with all-ones configuration before `xtal_en` is raised, so any setting that leaks through the override shows up. SPI-use masks 0xF and 0x5 are each run against opposing `spi_oe`/`spi_out` patterns, which separates taken-over pins from pins left in GPIO mode. A final stretch of random writes, pad inputs and override toggles, compared every cycle against a behavioural model, checks the pipeline latencies.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int CFG_BITS = 7;
  localparam int SPI_PINS = 4;
  localparam int DATA_W   = 8;

  typedef struct packed {
    logic irq_en;
    logic irq_low;
    logic ttl;
    logic hsink;
    logic od;
    logic pu;
    logic oe;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [NUM_PINS-1:0]          pin_sync_i,
  output logic [NUM_PINS*CFG_BITS-1:0] cfg_o,
  output logic [NUM_PINS-1:0]          data_o,
  output logic [SPI_PINS-1:0]          spi_use_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] A_SPI  = ADDR_W'(NUM_PINS + 1);

  logic [CFG_BITS-1:0] cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] data_q;
  logic [SPI_PINS-1:0] use_q;
  logic                past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= '0;
      data_q  <= '0;
      use_q   <= '0;
      rdata   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (wr_en) begin
        if (addr < A_DATA) cfg_q[addr[IDX_W-1:0]] <= wdata[CFG_BITS-1:0];
        else if (addr == A_DATA) data_q <= wdata[NUM_PINS-1:0];
        else if (addr == A_SPI) use_q <= wdata[SPI_PINS-1:0];
      end
      if (addr < A_DATA)       rdata <= {1'b0, cfg_q[addr[IDX_W-1:0]]};
      else if (addr == A_DATA) rdata <= DATA_W'(pin_sync_i);
      else if (addr == A_SPI)  rdata <= DATA_W'(use_q);
      else                     rdata <= '0;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    assign cfg_o[p*CFG_BITS +: CFG_BITS] = cfg_q[p];
  end
  assign data_o    = data_q;
  assign spi_use_o = use_q;

  // R2: reserved bit of a configuration read is always zero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(addr) < A_DATA) |-> (rdata[7] == 1'b0));
  // R1: read data is cleared by reset
  a_r1_rdata_reset: assert property (@(posedge clk)
    $past(rst) |-> (rdata == '0));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_BITS-1:0] cfg_i,
  input  logic                data_i,
  input  logic                xtal_take_i,
  input  logic                spi_take_i,
  input  logic                spi_oe_i,
  input  logic                spi_out_i,
  output logic                pad_out_o,
  output logic                pad_oe_o,
  output logic                pad_pu_o,
  output logic                pad_hsink_o,
  output logic                pad_ttl_o,
  output logic                irq_en_o,
  output logic                irq_low_o
);
  pin_cfg_t c;
  logic     gpio_mode;
  logic     nx_out, nx_oe;
  logic     past_ok;

  assign c         = pin_cfg_t'(cfg_i);
  assign gpio_mode = !xtal_take_i && !spi_take_i;

  always_comb begin
    if (xtal_take_i) begin
      nx_oe  = 1'b0;
      nx_out = 1'b0;
    end else if (spi_take_i) begin
      nx_oe  = spi_oe_i;
      nx_out = spi_oe_i & spi_out_i;
    end else if (!c.oe) begin
      nx_oe  = 1'b0;
      nx_out = 1'b0;
    end else if (c.od) begin
      nx_oe  = !data_i;
      nx_out = 1'b0;
    end else begin
      nx_oe  = 1'b1;
      nx_out = data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_o   <= 1'b0;
      pad_oe_o    <= 1'b0;
      pad_pu_o    <= 1'b0;
      pad_hsink_o <= 1'b0;
      pad_ttl_o   <= 1'b0;
      irq_en_o    <= 1'b0;
      irq_low_o   <= 1'b0;
      past_ok     <= 1'b0;
    end else begin
      past_ok     <= 1'b1;
      pad_out_o   <= nx_out;
      pad_oe_o    <= nx_oe;
      pad_pu_o    <= !xtal_take_i && c.pu;
      pad_hsink_o <= !xtal_take_i && c.hsink;
      pad_ttl_o   <= !xtal_take_i && c.ttl;
      irq_en_o    <= !xtal_take_i && c.irq_en;
      irq_low_o   <= !xtal_take_i && c.irq_low;
    end
  end

  // R5: disabled driver in GPIO mode
  a_r5_oe_off: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(gpio_mode && !c.oe) |-> !pad_oe_o);
  // R4: open drain with data 1 floats
  a_r4_od_hiz: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(gpio_mode && c.oe && c.od && data_i) |-> !pad_oe_o);
  // R7: crystal takeover silences the pin
  a_r7_xtal_quiet: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(xtal_take_i) |-> !pad_oe_o && !pad_pu_o && !irq_en_o);
  // R8: SPI takeover follows the peripheral enable
  a_r8_spi_follow: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(spi_take_i && !xtal_take_i) |-> (pad_oe_o == $past(spi_oe_i)));
  // R10: no high output while undriven
  a_r10_out_needs_oe: assert property (@(posedge clk) disable iff (rst)
    pad_out_o |-> pad_oe_o);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int ADDR_W       = $clog2(NUM_PINS + 2),
  parameter int XTAL_IN_PIN  = 0,
  parameter int XTAL_OUT_PIN = 1,
  parameter int SPI_BASE     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                xtal_en,
  input  logic [3:0]          spi_oe,
  input  logic [3:0]          spi_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_hsink,
  output logic [NUM_PINS-1:0] pad_ttl,
  output logic [NUM_PINS-1:0] irq_en,
  output logic [NUM_PINS-1:0] irq_low
);
  logic [NUM_PINS*CFG_BITS-1:0] cfg_flat;
  logic [NUM_PINS-1:0]          data_q;
  logic [NUM_PINS-1:0]          pin_sync;
  logic [SPI_PINS-1:0]          spi_use;

  gpio_in_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(pad_in), .q_o(pin_sync)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pin_sync_i(pin_sync),
    .cfg_o(cfg_flat), .data_o(data_q), .spi_use_o(spi_use)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam bit IS_X = (i == XTAL_IN_PIN) || (i == XTAL_OUT_PIN);
    localparam bit IS_S = (i >= SPI_BASE) && (i < SPI_BASE + SPI_PINS);
    localparam int SLOT = IS_S ? (i - SPI_BASE) : 0;
    logic xt, st, so, sd;

    if (IS_X) begin : g_x
      assign xt = xtal_en;
    end else begin : g_nx
      assign xt = 1'b0;
    end

    if (IS_S) begin : g_s
      assign st = spi_use[SLOT];
      assign so = spi_oe[SLOT];
      assign sd = spi_out[SLOT];
    end else begin : g_ns
      assign st = 1'b0;
      assign so = 1'b0;
      assign sd = 1'b0;
    end

    gpio_pin_ctrl u_pin (
      .clk(clk), .rst(rst),
      .cfg_i(cfg_flat[i*CFG_BITS +: CFG_BITS]),
      .data_i(data_q[i]),
      .xtal_take_i(xt), .spi_take_i(st), .spi_oe_i(so), .spi_out_i(sd),
      .pad_out_o(pad_out[i]), .pad_oe_o(pad_oe[i]), .pad_pu_o(pad_pu[i]),
      .pad_hsink_o(pad_hsink[i]), .pad_ttl_o(pad_ttl[i]),
      .irq_en_o(irq_en[i]), .irq_low_o(irq_low[i])
    );
  end
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic xtal_en = 1'b0;
  logic [3:0] spi_oe = '0, spi_out = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_hsink, pad_ttl, irq_en, irq_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xtal_en(xtal_en),
    .spi_oe(spi_oe), .spi_out(spi_out), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_hsink(pad_hsink), .pad_ttl(pad_ttl), .irq_en(irq_en), .irq_low(irq_low)
  );

  // behavioural model state
  int m_cfg [N];
  int m_data, m_use;
  int hist [$];
  logic [7:0] e_out, e_oe, e_pu, e_hs, e_ttl, e_ie, e_il, e_rd;
  bit started = 0;
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int i = 0; i < N; i++) m_cfg[i] = 0;
      m_data = 0; m_use = 0;
      hist = {0, 0};
      {e_out, e_oe, e_pu, e_hs, e_ttl, e_ie, e_il, e_rd} = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        int c;
        int d;
        c = m_cfg[i];
        d = (m_data >> i) & 1;
        e_out[i] = 0; e_oe[i] = 0;
        e_pu[i] = c[1]; e_hs[i] = c[3]; e_ttl[i] = c[4];
        e_il[i] = c[5]; e_ie[i] = c[6];
        if (i < 2 && xtal_en) begin
          {e_pu[i], e_hs[i], e_ttl[i], e_il[i], e_ie[i]} = '0;
        end else if (i >= 3 && i < 7 && m_use[i-3]) begin
          e_oe[i]  = spi_oe[i-3];
          e_out[i] = spi_oe[i-3] & spi_out[i-3];
        end else if (c[0]) begin
          if (c[2]) e_oe[i] = (d == 0);
          else begin e_oe[i] = 1; e_out[i] = d[0]; end
        end
      end
      if (reg_addr < N)       e_rd = 8'(m_cfg[reg_addr]);
      else if (reg_addr == N) e_rd = 8'(hist[0]);
      else if (reg_addr == N+1) e_rd = 8'(m_use);
      else e_rd = 0;
      void'(hist.pop_front());
      hist.push_back(int'(pad_in));
      if (reg_wr) begin
        if (reg_addr < N) m_cfg[reg_addr] = reg_wdata & 8'h7F;
        else if (reg_addr == N) m_data = reg_wdata;
        else if (reg_addr == N+1) m_use = reg_wdata & 8'h0F;
      end
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      checks++;
      cmp("pad_out", pad_out, e_out);
      cmp("pad_oe", pad_oe, e_oe);
      cmp("pad_pu", pad_pu, e_pu);
      cmp("pad_hsink", pad_hsink, e_hs);
      cmp("pad_ttl", pad_ttl, e_ttl);
      cmp("irq_en", irq_en, e_ie);
      cmp("irq_low", irq_low, e_il);
      cmp("reg_rdata", reg_rdata, e_rd);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    tick();
    reg_wr = 0;
  endtask

  task automatic all_cfg(int d);
    for (int i = 0; i < N; i++) wr(i, d);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1"; tick(3); rst = 0; tick(3);
    cur_req = "R2";
    wr(2, 8'hFF); reg_addr = 2; tick(2);
    wr(5, 8'h80); reg_addr = 5; tick(2);
    wr(5, 8'h00);
    cur_req = "R3";
    all_cfg(8'h01); wr(N, 8'hAA); tick(2); wr(N, 8'h55); tick(2);
    cur_req = "R4";
    all_cfg(8'h05); wr(N, 8'hF0); tick(2); wr(N, 8'h0F); tick(2);
    cur_req = "R5";
    all_cfg(8'h06); wr(N, 8'hAA); tick(2); wr(N, 8'h00); tick(2);
    cur_req = "R6";
    all_cfg(8'h5A); tick(2); all_cfg(8'h27); wr(N, 8'hFF); tick(2);
    cur_req = "R7";
    wr(0, 8'h7F); wr(1, 8'h7F); wr(N, 8'hFF); xtal_en = 1; tick(3);
    wr(N, 8'h00); tick(2); xtal_en = 0; tick(2);
    cur_req = "R8";
    all_cfg(8'h01); wr(N, 8'hFF); wr(N+1, 8'h0F); reg_addr = N+1;
    spi_oe = 4'hF; spi_out = 4'hA; tick(2);
    spi_oe = 4'h5; spi_out = 4'hF; tick(2);
    wr(N+1, 8'h05); spi_oe = 4'hA; spi_out = 4'h5; tick(3);
    wr(N+1, 8'h00); tick(2);
    cur_req = "R9";
    reg_addr = N;
    pad_in = 8'hC3; tick(4); pad_in = 8'h3C; tick(1); pad_in = 8'h81; tick(4);
    cur_req = "R10";
    for (int k = 0; k < 400; k++) begin
      reg_wr = ($urandom % 3) == 0;
      reg_addr = AW'($urandom % (N + 3));
      reg_wdata = 8'($urandom);
      pad_in = 8'($urandom);
      spi_oe = 4'($urandom); spi_out = 4'($urandom);
      if (($urandom % 8) == 0) xtal_en = ~xtal_en;
      tick();
    end
    reg_wr = 0;
    cur_req = "R1";
    rst = 1; tick(2); rst = 0; tick(2);
    finish_run();
  end
endmodule